// File: doc/BRIEF.md
# Flash Operation Completion Poller

This block waits for a parallel NOR flash to finish an internal program or erase cycle. It does this by reading one status location over and over. After a start request it latches a configuration: a completion criterion, the address to poll, the byte that was written, and a pause length in microseconds. It then issues single-byte read requests on a simple request/valid read port until the chosen criterion is met or an iteration ceiling is reached.

There are two criteria. In toggle mode, the device is busy while bit 6 of successive reads keeps flipping, so the poller finishes once two back-to-back reads agree on that bit. In data-polling mode, bit 7 of the status byte reads as the complement of the written data until the operation ends, so the poller finishes once bit 7 equals bit 7 of the expected byte.

A programmable pause, counted in clock cycles through a per-microsecond prescaler, separates each read from the next. A short pause suits program waits and a long one suits erase waits. When the block finishes it pulses `done`. It also reports whether the ceiling was hit without completion, and whether the number of reads went past a warning threshold.

Top module: `flash_done_poller`

## Requirements
- R1: After reset, `busy`, `done`, `timedOut`, `overLimit` and `rdReq` are all low.
- R2: A start accepted while idle raises `rdReq` in the very next cycle. `rdReq` is always a single-cycle pulse, and `rdAddr` equals the `pollAddr` latched at start for every request.
- R3: Toggle mode (`modeData`=0) looks only at bit 6 of each returned byte. The first read only sets the reference. Each later read is counted and completes the wait if its bit 6 equals bit 6 of the read just before it; otherwise it becomes the new reference.
- R4: Data-polling mode (`modeData`=1) looks only at bit 7. Every read is counted, and the wait completes at the first read whose bit 7 equals bit 7 of the `expData` latched at start.
- R5: The first read is issued with no pause. Each later `rdReq` rises exactly `delayUs`*CYC_PER_US+2 cycles after the cycle in which the previous `rdValid` was accepted.
- R6: When the counted reads reach MAX_ITER without completion, polling stops, `timedOut` goes high and `done` is still pulsed. If completion is seen on the last permitted read, `timedOut` stays low.
- R7: At finish, `overLimit` goes high exactly when the number of counted reads is greater than WARN_ITER.
- R8: `done` is a one-cycle pulse in the cycle after the last `rdValid`, with `busy` already low. `timedOut` and `overLimit` keep their values until the next accepted start, which clears them.
- R9: A start request while `busy` is high is ignored. The operation in progress keeps its mode, address and expected data and ends exactly as it would have without that request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a wait; sampled only while idle |
| modeData | input | 1 | 0 = toggle criterion, 1 = data-polling criterion |
| pollAddr | input | ADDR_W | Location to read repeatedly |
| expData | input | DATA_W | Byte that was written (bit 7 used in data-polling mode) |
| delayUs | input | DLY_W | Pause between reads, in microseconds |
| rdReq | output | 1 | One-cycle read request |
| rdAddr | output | ADDR_W | Read address |
| rdData | input | DATA_W | Returned byte, qualified by rdValid |
| rdValid | input | 1 | Returned byte is valid this cycle |
| busy | output | 1 | A wait is in progress |
| done | output | 1 | One-cycle pulse when the wait ends |
| timedOut | output | 1 | Last wait hit the iteration ceiling without completion |
| overLimit | output | 1 | Last wait counted more reads than the warning threshold |

## Verification
The bench builds the poller with MAX_ITER=6, WARN_ITER=3, CYC_PER_US=2 and a 4-bit pause field. With these values, completion before, at and beyond both the warning threshold and the ceiling can be reached within a few reads. The bench sweeps both modes over every completion point from the first read to past the ceiling. It uses pauses of 0, 1 and 3 microseconds and read latencies of one and three cycles. It predicts the read count, the request spacing and both flags arithmetically. Bits outside the one under test change on every read, and a second start with different settings is injected mid-wait.

// File: rtl/flash_poll_pkg.sv
package flash_poll_pkg;

  // Bit positions the device uses to signal progress.
  localparam int TOGGLE_POS = 6;
  localparam int DPOLL_POS  = 7;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_AWAIT = 2'd2,
    ST_PAUSE = 2'd3
  } pollState_e;

  // Strobes from control to datapath.
  typedef struct packed {
    logic latchCfg;  // capture configuration, clear result flags
    logic loadRef;   // keep newest toggle bit as reference
    logic incIter;   // one more counted read
    logic loadDly;   // arm pause counter
    logic decDly;    // count pause down
    logic finish;    // end the wait, publish result
  } pollStrobe_t;

endpackage

// File: rtl/fpoll_datapath.sv
module fpoll_datapath
  import flash_poll_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DLY_W      = 14,
  parameter int CYC_PER_US = 100,
  parameter int MAX_ITER   = 32'h0FFF_FFFF,
  parameter int WARN_ITER  = 32'h0010_0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  pollStrobe_t       stb,
  input  logic              cfgMode,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic              cfgExpBit,
  input  logic [DLY_W-1:0]  cfgDelayUs,
  input  logic              togBit,
  input  logic              pollBit,
  output logic              modeData,
  output logic [ADDR_W-1:0] rdAddr,
  output logic              sampleMatch,
  output logic              atLimit,
  output logic              dlyZero,
  output logic              done,
  output logic              timedOut,
  output logic              overLimit
);

  localparam int PRE_W  = $clog2(CYC_PER_US + 1);
  localparam int CNT_W  = DLY_W + PRE_W;
  localparam int ITER_W = $clog2(MAX_ITER + 1);
  localparam logic [ITER_W-1:0] ITER_LIMIT = ITER_W'(MAX_ITER);
  localparam logic [ITER_W-1:0] ITER_WARN  = ITER_W'(WARN_ITER);

  logic              modeQ;
  logic [ADDR_W-1:0] addrQ;
  logic              expBitQ;
  logic [DLY_W-1:0]  dlyUsQ;
  logic              refBitQ;
  logic [ITER_W-1:0] iterQ;
  logic [CNT_W-1:0]  dlyCntQ;
  logic              doneQ;
  logic              timedOutQ;
  logic              overLimitQ;

  logic [ITER_W-1:0] nextIter;
  logic [CNT_W-1:0]  dlyLoad;

  // Pause length in cycles: microseconds times the prescale.
  generate
    if (CYC_PER_US == 1) begin : g_unit
      assign dlyLoad = CNT_W'(dlyUsQ);
    end else begin : g_scaled
      assign dlyLoad = CNT_W'(dlyUsQ) * CNT_W'(CYC_PER_US);
    end
  endgenerate

  assign nextIter = iterQ + ITER_W'(1);
  assign atLimit  = (nextIter == ITER_LIMIT);
  assign dlyZero  = (dlyCntQ == '0);

  // Completion test on the byte being returned this cycle.
  always_comb begin
    if (modeQ) sampleMatch = (pollBit == expBitQ);
    else       sampleMatch = (togBit == refBitQ);
  end

  // Configuration captured at start.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ   <= 1'b0;
      addrQ   <= '0;
      expBitQ <= 1'b0;
      dlyUsQ  <= '0;
    end else if (stb.latchCfg) begin
      modeQ   <= cfgMode;
      addrQ   <= cfgAddr;
      expBitQ <= cfgExpBit;
      dlyUsQ  <= cfgDelayUs;
    end
  end

  // Toggle reference bit.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            refBitQ <= 1'b0;
    else if (stb.loadRef) refBitQ <= togBit;
  end

  // Counted-read counter.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             iterQ <= '0;
    else if (stb.latchCfg) iterQ <= '0;
    else if (stb.incIter)  iterQ <= nextIter;
  end

  // Pause counter.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          dlyCntQ <= '0;
    else if (stb.loadDly)               dlyCntQ <= dlyLoad;
    else if (stb.decDly && !dlyZero)    dlyCntQ <= dlyCntQ - CNT_W'(1);
  end

  // Result flags and completion pulse.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      doneQ      <= 1'b0;
      timedOutQ  <= 1'b0;
      overLimitQ <= 1'b0;
    end else begin
      doneQ <= stb.finish;
      if (stb.latchCfg) begin
        timedOutQ  <= 1'b0;
        overLimitQ <= 1'b0;
      end else if (stb.finish) begin
        timedOutQ  <= !sampleMatch;
        overLimitQ <= (nextIter > ITER_WARN);
      end
    end
  end

  assign modeData  = modeQ;
  assign rdAddr    = addrQ;
  assign done      = doneQ;
  assign timedOut  = timedOutQ;
  assign overLimit = overLimitQ;

endmodule

// File: rtl/fpoll_control.sv
module fpoll_control
  import flash_poll_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        rdValid,
  input  logic        modeData,
  input  logic        sampleMatch,
  input  logic        atLimit,
  input  logic        dlyZero,
  output pollStrobe_t stb,
  output logic        rdReq,
  output logic        busy
);

  pollState_e stateQ, nextState;
  logic       firstQ, nextFirst;

  always_comb begin
    stb       = '0;
    nextState = stateQ;
    nextFirst = firstQ;
    unique case (stateQ)
      ST_IDLE: begin
        if (start) begin
          stb.latchCfg = 1'b1;
          nextFirst    = 1'b1;
          nextState    = ST_ISSUE;
        end
      end
      ST_ISSUE: nextState = ST_AWAIT;
      ST_AWAIT: begin
        if (rdValid) begin
          nextFirst = 1'b0;
          if (firstQ && !modeData) begin
            // Toggle mode: first byte only seeds the reference.
            stb.loadRef = 1'b1;
            stb.loadDly = 1'b1;
            nextState   = ST_PAUSE;
          end else begin
            stb.incIter = 1'b1;
            if (sampleMatch || atLimit) begin
              stb.finish = 1'b1;
              nextState  = ST_IDLE;
            end else begin
              stb.loadRef = 1'b1;
              stb.loadDly = 1'b1;
              nextState   = ST_PAUSE;
            end
          end
        end
      end
      ST_PAUSE: begin
        if (dlyZero) nextState = ST_ISSUE;
        else         stb.decDly = 1'b1;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      firstQ <= 1'b0;
    end else begin
      stateQ <= nextState;
      firstQ <= nextFirst;
    end
  end

  assign rdReq = (stateQ == ST_ISSUE);
  assign busy  = (stateQ != ST_IDLE);

endmodule

// File: rtl/flash_done_poller.sv
module flash_done_poller
  import flash_poll_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 8,
  parameter int DLY_W      = 14,
  parameter int CYC_PER_US = 100,
  parameter int MAX_ITER   = 32'h0FFF_FFFF,
  parameter int WARN_ITER  = 32'h0010_0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              modeData,
  input  logic [ADDR_W-1:0] pollAddr,
  input  logic [DATA_W-1:0] expData,
  input  logic [DLY_W-1:0]  delayUs,
  output logic              rdReq,
  output logic [ADDR_W-1:0] rdAddr,
  input  logic [DATA_W-1:0] rdData,
  input  logic              rdValid,
  output logic              busy,
  output logic              done,
  output logic              timedOut,
  output logic              overLimit
);

  pollStrobe_t stb;
  logic        latchedMode;
  logic        sampleMatch;
  logic        atLimit;
  logic        dlyZero;
  logic        unusedBits;

  // Only two bit positions of the data buses carry meaning here.
  assign unusedBits = ^{rdData, expData};

  fpoll_control ctl_i (
    .clk        (clk),
    .rstN       (rstN),
    .start      (start),
    .rdValid    (rdValid),
    .modeData   (latchedMode),
    .sampleMatch(sampleMatch),
    .atLimit    (atLimit),
    .dlyZero    (dlyZero),
    .stb        (stb),
    .rdReq      (rdReq),
    .busy       (busy)
  );

  fpoll_datapath #(
    .ADDR_W    (ADDR_W),
    .DLY_W     (DLY_W),
    .CYC_PER_US(CYC_PER_US),
    .MAX_ITER  (MAX_ITER),
    .WARN_ITER (WARN_ITER)
  ) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .cfgMode    (modeData),
    .cfgAddr    (pollAddr),
    .cfgExpBit  (expData[DPOLL_POS]),
    .cfgDelayUs (delayUs),
    .togBit     (rdData[TOGGLE_POS]),
    .pollBit    (rdData[DPOLL_POS]),
    .modeData   (latchedMode),
    .rdAddr     (rdAddr),
    .sampleMatch(sampleMatch),
    .atLimit    (atLimit),
    .dlyZero    (dlyZero),
    .done       (done),
    .timedOut   (timedOut),
    .overLimit  (overLimit)
  );

endmodule

// File: rtl/fpoll_checker.sv
module fpoll_checker (
  input logic clk,
  input logic rstN,
  input logic start,
  input logic rdReq,
  input logic busy,
  input logic done,
  input logic timedOut,
  input logic overLimit
);

  // R2: a read request lasts one cycle
  p_req_pulse_r2: assert property (@(posedge clk) disable iff (!rstN)
    rdReq |=> !rdReq);

  // R1: no request while idle
  p_req_idle_r1: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !rdReq);

  // R8: done is a single pulse seen while idle
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  // R8: flags hold while idle with no start
  p_flags_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !start) |=> ($stable(timedOut) && $stable(overLimit)));

  // R6: timeout only rises together with done
  p_timeout_done_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(timedOut) |-> done);

  // R7: warning only rises together with done
  p_warn_done_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overLimit) |-> done);

  // R9: a busy wait only ends through done
  p_busy_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> (busy || done));

endmodule

bind flash_done_poller fpoll_checker chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .start    (start),
  .rdReq    (rdReq),
  .busy     (busy),
  .done     (done),
  .timedOut (timedOut),
  .overLimit(overLimit)
);

// File: tb/flash_done_poller_tb_top.sv
`timescale 1ns/100ps
module flash_done_poller_tb_top;

  localparam int ADDR_W = 16;
  localparam int DATA_W = 8;
  localparam int DLY_W  = 4;
  localparam int CPU    = 2;
  localparam int MAXI   = 6;
  localparam int WARNI  = 3;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              start = 1'b0;
  logic              modeData = 1'b0;
  logic [ADDR_W-1:0] pollAddr = '0;
  logic [DATA_W-1:0] expData = '0;
  logic [DLY_W-1:0]  delayUs = '0;
  logic              rdReq;
  logic [ADDR_W-1:0] rdAddr;
  logic [DATA_W-1:0] rdData = '0;
  logic              rdValid = 1'b0;
  logic              busy, done, timedOut, overLimit;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  flash_done_poller #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DLY_W(DLY_W),
    .CYC_PER_US(CPU), .MAX_ITER(MAXI), .WARN_ITER(WARNI)
  ) dut_i (
    .clk(clk), .rstN(rstN), .start(start), .modeData(modeData),
    .pollAddr(pollAddr), .expData(expData), .delayUs(delayUs),
    .rdReq(rdReq), .rdAddr(rdAddr), .rdData(rdData), .rdValid(rdValid),
    .busy(busy), .done(done), .timedOut(timedOut), .overLimit(overLimit)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Byte the modelled flash returns on read number k.
  function automatic logic [7:0] flashByte(input bit md, input int f,
                                           input logic e, input int k);
    logic b6, b7;
    int   fm1;
    fm1 = (f == 0) ? 0 : f - 1;
    if (md) begin
      b7 = (k < f) ? ~e : e;
      b6 = k[0];                        // keeps flipping, must be ignored
    end else begin
      b6 = (k < f) ? k[0] : fm1[0];
      b7 = k[1];                        // varies, must be ignored
    end
    return {b7, b6, 6'(k * 5 + f)};
  endfunction

  task automatic runOne(input bit md, input int f, input int dUs,
                        input int lat, input bit inj);
    int cnt, exReads, cyc, reads, lastValid, respAt, doneCyc, firstReq, gap;
    bit exTo, exOv, gotDone, gapOk, addrOk, pulseOk, prevReq;
    logic e;
    logic [ADDR_W-1:0] addr;
    addr = 16'h1000 + 16'(f * 16'h111) + 16'(dUs);
    e = f[0] ^ lat[1];
    if (md) begin
      cnt = (f + 1 > MAXI) ? MAXI : f + 1;
      exReads = cnt;
      exTo = (f + 1 > MAXI);
    end else begin
      int fe;
      fe = (f < 1) ? 1 : f;
      cnt = (fe > MAXI) ? MAXI : fe;
      exReads = cnt + 1;
      exTo = (fe > MAXI);
    end
    exOv = (cnt > WARNI);
    gap = dUs * CPU + 2;

    @(negedge clk);
    start = 1'b1; modeData = md; pollAddr = addr;
    expData = {e, 7'(f * 3)}; delayUs = DLY_W'(dUs);
    @(negedge clk);
    start = 1'b0;
    cyc = 1; reads = 0; lastValid = -1; respAt = -1; doneCyc = -1; firstReq = -1;
    gotDone = 0; gapOk = 1; addrOk = 1; pulseOk = 1; prevReq = 0;
    chk(!timedOut && !overLimit, "R8", "flags cleared by start", {timedOut, overLimit}, 0);
    while (!gotDone && cyc < 400) begin
      rdValid = 1'b0;
      if (rdReq) begin
        if (prevReq) pulseOk = 0;
        if (rdAddr != addr) addrOk = 0;
        if (reads == 0) firstReq = cyc;
        else if (cyc - lastValid != gap) gapOk = 0;
        respAt = cyc + lat;
        reads++;
      end
      prevReq = rdReq;
      if (cyc == respAt) begin
        rdValid = 1'b1;
        rdData = flashByte(md, f, e, reads - 1);
        lastValid = cyc;
      end
      if (done) begin gotDone = 1; doneCyc = cyc; end
      if (inj) begin
        start = (cyc == 3);
        if (cyc == 3) begin
          modeData = ~md; pollAddr = ~addr; expData = ~expData;
        end
      end
      @(negedge clk);
      cyc++;
    end
    rdValid = 1'b0; start = 1'b0;
    chk(firstReq == 1, "R2", "first request cycle", firstReq, 1);
    chk(pulseOk && addrOk, "R2", "request pulse/address", {pulseOk, addrOk}, 3);
    chk(reads == exReads, md ? "R4" : "R3", "reads before done", reads, exReads);
    chk(gapOk, "R5", "request spacing", gapOk, 1);
    chk(gotDone && doneCyc == lastValid + 1, "R8", "done cycle", doneCyc, lastValid + 1);
    chk(timedOut == exTo, "R6", "timeout flag", timedOut, exTo);
    chk(overLimit == exOv, "R7", "warning flag", overLimit, exOv);
    chk(!done && !busy, "R8", "done single cycle, idle", {done, busy}, 0);
    repeat (2) @(negedge clk);
    chk(timedOut == exTo && overLimit == exOv, "R8", "flags held",
        {timedOut, overLimit}, {exTo, exOv});
    if (inj) chk(reads == exReads && addrOk, "R9", "start while busy ignored", reads, exReads);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !timedOut && !overLimit && !rdReq, "R1", "reset state",
        {busy, done, timedOut, overLimit, rdReq}, 0);
    for (int md = 0; md < 2; md++)
      for (int f = 0; f <= 8; f++)
        for (int di = 0; di < 3; di++)
          for (int li = 0; li < 2; li++) begin
            int dUs, lat;
            dUs = (di == 2) ? 3 : di;
            lat = li ? 3 : 1;
            runOne(md[0], f, dUs, lat, (dUs == 1) && (lat == 3));
          end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule